// File: doc/BRIEF.md
# Three-Way DRAM Access Arbiter

This block decides which of three requesters may drive a shared DRAM controller in each cycle: a refresh source, Port A and Port B. It samples its inputs on the rising edge of the system clock and keeps at most one grant active at a time. Refresh ranks first, then Port A, then Port B. A port that has finished its access keeps the grant while nobody else asks for it, so a burst of accesses from that port goes on without a new arbitration. An active-low lock input holds the current port grant for atomic sequences.

Each change of owner goes through one cycle with no grant. This gives the DRAM its precharge time and lets the old port's request drop before the new owner starts. A settled flag rises one cycle after a grant appears and tells downstream logic that the multiplexed address is stable. A port-select output steers the address multiplexer. The Port B request is asynchronous and passes through a synchronizer before the arbiter sees it.

Top module: `dram_access_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all three grants, the settled flag and the port-select output are low.
- R2: At most one of the three grant outputs is high in any cycle.
- R3: With no grant active, an active refresh request gives the refresh grant at the next clock edge, ahead of any port request.
- R4: With no grant active and no refresh request, Port A is granted ahead of Port B when both request.
- R5: The Port A request has effect only while the Port A chip select is high. With the chip select low, Port A neither gains the grant nor takes it from a parked Port B.
- R6: A granted port keeps its grant, with the settled flag high, while neither refresh nor the other port requests.
- R7: While lock_ni is low, a granted port keeps its grant, even when refresh or the other port requests.
- R8: A granted port keeps its grant while its own request stays active (access in progress), even when refresh requests.
- R9: When the grant passes from one requester to another, the old grant drops and there is one full cycle with no grant before the new grant rises.
- R10: The settled flag is low in the first cycle of a grant. It is high from the second cycle on while that grant holds, and low whenever no grant is active.
- R11: The refresh grant lasts at least two cycles and stays while the refresh request stays active.
- R12: The Port B request passes through a two-stage synchronizer, so a Port B request raised before edge n is first seen by the arbiter at edge n+2.
- R13: port_sel_o is high exactly in the cycles in which Port B holds the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_req_i | input | 1 | Refresh request, synchronous |
| a_req_i | input | 1 | Port A access request, synchronous |
| a_cs_i | input | 1 | Port A chip select, qualifies a_req_i |
| b_req_i | input | 1 | Port B access request, asynchronous |
| lock_ni | input | 1 | Lock input, active low; holds the current port grant |
| gnt_ref_o | output | 1 | Refresh grant |
| gnt_a_o | output | 1 | Port A grant |
| gnt_b_o | output | 1 | Port B grant |
| gnt_settled_o | output | 1 | Grant has held for at least one full cycle |
| port_sel_o | output | 1 | Address mux select: 1 selects Port B |

## Verification
The hardest state to reach is a parked or locked port grant that is contested in the same cycle by refresh and by the other port. In that state, lock, the chip select and the two-cycle delay of the Port B synchronizer all act together. The directed part of the bench raises the Port B request two cycles ahead of Port A so that both are seen at one edge. It then parks Port B and applies a lock together with a refresh request. A long pseudo-random sweep follows with lock and refresh biased to be rare. Each cycle is compared against a cycle model built from the requirements.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;
  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_REF  = 2'd1,
    GNT_A    = 2'd2,
    GNT_B    = 2'd3
  } gnt_e;
endpackage

// File: rtl/dram_arb_sync.sv
module dram_arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dram_arb_next.sv
module dram_arb_next
  import dram_arb_pkg::*;
(
  input  gnt_e gnt_i,
  input  logic settled_i,
  input  logic ref_i,
  input  logic a_i,
  input  logic b_i,
  input  logic lock_i,
  output gnt_e gnt_o
);
  always_comb begin
    gnt_o = gnt_i;
    unique case (gnt_i)
      GNT_NONE: begin
        if (ref_i)    gnt_o = GNT_REF;
        else if (a_i) gnt_o = GNT_A;
        else if (b_i) gnt_o = GNT_B;
        else          gnt_o = GNT_NONE;
      end
      // refresh lasts at least until settled
      GNT_REF: gnt_o = (ref_i || !settled_i) ? GNT_REF : GNT_NONE;
      // owner keeps grant under lock or own access; parks otherwise
      GNT_A: begin
        if (lock_i || a_i)      gnt_o = GNT_A;
        else if (ref_i || b_i)  gnt_o = GNT_NONE;
        else                    gnt_o = GNT_A;
      end
      GNT_B: begin
        if (lock_i || b_i)      gnt_o = GNT_B;
        else if (ref_i || a_i)  gnt_o = GNT_NONE;
        else                    gnt_o = GNT_B;
      end
      default: gnt_o = GNT_NONE;
    endcase
  end
endmodule

// File: rtl/dram_access_arbiter.sv
module dram_access_arbiter
  import dram_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_req_i,
  input  logic a_req_i,
  input  logic a_cs_i,
  input  logic b_req_i,
  input  logic lock_ni,
  output logic gnt_ref_o,
  output logic gnt_a_o,
  output logic gnt_b_o,
  output logic gnt_settled_o,
  output logic port_sel_o
);
  gnt_e gnt_q, gnt_d;
  logic settled_q;
  logic b_req_sync;
  logic a_req_eff;

  dram_arb_sync #(.STAGES(SYNC_STAGES)) u_b_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (b_req_i),
    .q_o   (b_req_sync)
  );

  assign a_req_eff = a_req_i & a_cs_i;

  dram_arb_next u_next (
    .gnt_i    (gnt_q),
    .settled_i(settled_q),
    .ref_i    (ref_req_i),
    .a_i      (a_req_eff),
    .b_i      (b_req_sync),
    .lock_i   (~lock_ni),
    .gnt_o    (gnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q     <= GNT_NONE;
      settled_q <= 1'b0;
    end else begin
      gnt_q     <= gnt_d;
      settled_q <= (gnt_q != GNT_NONE) && (gnt_d == gnt_q);
    end
  end

  assign gnt_ref_o     = (gnt_q == GNT_REF);
  assign gnt_a_o       = (gnt_q == GNT_A);
  assign gnt_b_o       = (gnt_q == GNT_B);
  assign gnt_settled_o = settled_q;
  assign port_sel_o    = (gnt_q == GNT_B);
endmodule

// File: rtl/dram_access_arbiter_chk.sv
module dram_access_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_req_i,
  input logic a_req_i,
  input logic a_cs_i,
  input logic lock_ni,
  input logic b_sync_i,
  input logic gnt_ref_o,
  input logic gnt_a_o,
  input logic gnt_b_o,
  input logic gnt_settled_o
);
  logic idle;
  assign idle = !gnt_ref_o && !gnt_a_o && !gnt_b_o;

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gnt_ref_o, gnt_a_o, gnt_b_o}));

  a_r3_ref_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && ref_req_i) |=> gnt_ref_o);

  a_r4_a_over_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !ref_req_i && a_req_i && a_cs_i) |=> gnt_a_o);

  a_r5_cs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !ref_req_i && !b_sync_i && a_req_i && !a_cs_i) |=> idle);

  a_r6_park_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_a_o && !ref_req_i && !b_sync_i) |=> gnt_a_o);

  a_r7_lock_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_a_o && !lock_ni) |=> gnt_a_o);

  a_r7_lock_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_b_o && !lock_ni) |=> gnt_b_o);

  a_r8_busy_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_b_o && b_sync_i) |=> gnt_b_o);

  a_r9_gap_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_a_o |=> (!gnt_b_o && !gnt_ref_o));

  a_r9_gap_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_b_o |=> (!gnt_a_o && !gnt_ref_o));

  a_r9_gap_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_ref_o |=> (!gnt_a_o && !gnt_b_o));

  a_r10_settle_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gnt_ref_o) || $rose(gnt_a_o) || $rose(gnt_b_o)) |-> !gnt_settled_o);

  a_r10_settle_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !gnt_settled_o);

  a_r11_ref_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_ref_o) |=> gnt_ref_o);
endmodule

bind dram_access_arbiter dram_access_arbiter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ref_req_i    (ref_req_i),
  .a_req_i      (a_req_i),
  .a_cs_i       (a_cs_i),
  .lock_ni      (lock_ni),
  .b_sync_i     (b_req_sync),
  .gnt_ref_o    (gnt_ref_o),
  .gnt_a_o      (gnt_a_o),
  .gnt_b_o      (gnt_b_o),
  .gnt_settled_o(gnt_settled_o)
);

// File: tb/dram_access_arbiter_tb.sv
module dram_access_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_req = 1'b0, a_req = 1'b0, a_cs = 1'b0, b_req = 1'b0, lock_n = 1'b1;
  logic gnt_ref, gnt_a, gnt_b, settled, port_sel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state: 0 none, 1 refresh, 2 A, 3 B
  int mg = 0;
  bit ms = 1'b0, mb1 = 1'b0, mb2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_access_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ref_req_i(ref_req), .a_req_i(a_req), .a_cs_i(a_cs),
    .b_req_i(b_req), .lock_ni(lock_n),
    .gnt_ref_o(gnt_ref), .gnt_a_o(gnt_a), .gnt_b_o(gnt_b),
    .gnt_settled_o(settled), .port_sel_o(port_sel)
  );

  function automatic int model_next(int g, bit rr, bit ra, bit rb, bit lk, bit st);
    case (g)
      0: return rr ? 1 : ra ? 2 : rb ? 3 : 0;
      1: return (rr || !st) ? 1 : 0;
      2: return (lk || ra) ? 2 : (rr || rb) ? 0 : 2;
      default: return (lk || rb) ? 3 : (rr || ra) ? 0 : 3;
    endcase
  endfunction

  function automatic int dut_gnt();
    return {29'd0, gnt_b, gnt_a, gnt_ref};
  endfunction

  function automatic int code_vec(int g);
    return (g == 0) ? 0 : (1 << (g - 1));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit rr, bit ra, bit cs, bit b, bit lk);
    int ng;
    @(negedge clk);
    ref_req = rr; a_req = ra; a_cs = cs; b_req = b; lock_n = !lk;
    @(posedge clk);
    ng  = model_next(mg, rr, ra & cs, mb2, lk, ms);
    ms  = (mg != 0) && (ng == mg);
    mg  = ng;
    mb2 = mb1;
    mb1 = b;
    #1;
    check(dut_gnt() == code_vec(mg), "R2/R9 grants vs model", dut_gnt(), code_vec(mg));
    check(settled == ms, "R10 settled vs model", settled, ms);
    check(port_sel == (mg == 3), "R13 port_sel vs model", port_sel, (mg == 3));
  endtask

  task automatic expg(int g, string tag);
    check(dut_gnt() == code_vec(g), tag, dut_gnt(), code_vec(g));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check({gnt_ref, gnt_a, gnt_b, settled, port_sel} == 5'b0, "R1 reset outputs",
          {gnt_ref, gnt_a, gnt_b, settled, port_sel}, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    check({gnt_ref, gnt_a, gnt_b, settled} == 4'b0, "R1 first cycle after reset",
          {gnt_ref, gnt_a, gnt_b, settled}, 0);

    // refresh from idle, minimum length
    cyc(1, 0, 0, 0, 0); expg(1, "R3 refresh granted next edge");
    check(settled == 1'b0, "R10 settled low in first grant cycle", settled, 0);
    cyc(0, 0, 0, 0, 0); expg(1, "R11 refresh held two cycles");
    check(settled == 1'b1, "R10 settled high in second cycle", settled, 1);
    cyc(0, 0, 0, 0, 0); expg(0, "R11 refresh released");

    // B synchronizer latency, then A over B
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0); expg(0, "R12 B not seen before two edges");
    cyc(0, 1, 1, 1, 0); expg(2, "R4 A wins over B");
    cyc(0, 0, 0, 1, 0); expg(0, "R9 idle cycle on A to B switch");
    cyc(0, 0, 0, 1, 0); expg(3, "R9 B granted after gap");
    check(port_sel == 1'b1, "R13 port_sel with B grant", port_sel, 1);

    // parking on B
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); expg(3, "R6 B parked");
    check(settled == 1'b1, "R6 settled while parked", settled, 1);
    cyc(0, 1, 0, 0, 0); expg(3, "R5 A without chip select ignored");

    // lock holds B against refresh
    cyc(1, 0, 0, 0, 1); expg(3, "R7 lock holds B vs refresh");
    cyc(1, 1, 1, 0, 1); expg(3, "R7 lock holds B vs refresh and A");
    cyc(1, 0, 0, 0, 0); expg(0, "R9 idle after lock release");
    cyc(1, 0, 0, 0, 0); expg(1, "R3 refresh after gap");
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); expg(0, "R11 refresh done");

    // access in progress not preempted
    cyc(0, 1, 1, 0, 0); expg(2, "R4 A granted");
    cyc(1, 1, 1, 0, 0); expg(2, "R8 A access holds vs refresh");
    cyc(1, 0, 1, 0, 0); expg(0, "R9 idle after A ends");
    cyc(1, 0, 0, 0, 0); expg(1, "R3 refresh after A");
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);

    // pseudo-random sweep against the cycle model
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0] == 4'd0, lfsr[8], lfsr[9] | lfsr[10], lfsr[11], lfsr[7:5] == 3'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule